// File: doc/BRIEF.md
# Address Line Walking Tester

This block checks whether every address line of a memory really reaches the storage array. A broken or shorted address line makes two addresses that differ in that line land on the same physical word. The tester picks a probe address and visits partner addresses that differ from it in exactly one bit. For each partner it reads the partner word and writes the inverse of that value to the probe address. It then reads the partner again. If the second read returns the inverse, the write to the probe reached the partner, and the two addresses are aliased.

One start pulse runs two passes over one region, which is given by a byte base address and a byte size. In the first pass the probe is the region base. In the second pass the probe is the last 64-bit word of the region. Within a pass, the single-bit mask begins at the word width in bytes and climbs one bit per step until it shifts out. Partners that fall outside the region are skipped without any memory access. A detected alias does not stop the walk. The tester reports one pass/fail verdict and keeps the probe address, partner address and mask of the first alias found. It drives a single synchronous memory port whose read data arrives one cycle after the request.

Top module: `addr_line_walker`

## Requirements
- R1: After reset, and until `start` is seen, `busy`, `done` and `fail` are 0 and `mem_req` stays 0.
- R2: Within each pass, the mask takes the values WORD_BYTES, 2·WORD_BYTES, … up to the top address bit, once each, in rising order. Every partner inside the region gets exactly one write to the probe address per pass.
- R3: A partner address (probe XOR mask) is used only if base ≤ partner < base+size. Otherwise that step makes no memory access, so every `mem_addr` presented lies inside the region.
- R4: For each accepted partner, the port sees, in this order: a read of the partner; a write to the probe address whose data is the bitwise inverse of that read's data; and a second read of the partner.
- R5: An alias is flagged when the second partner read equals the inverse that was written. The first alias of a run sets `fault_test_addr`, `fault_target_addr` and `fault_mask`, and later aliases leave these fields unchanged.
- R6: The first pass uses the probe address base. The second pass uses the probe address base+size−8, truncated to the address width.
- R7: An alias does not shorten the walk. The number of accesses is the same with or without faults.
- R8: `done` rises after the last step of the second pass and stays high until the next `start`. While `done` is high, `fail` is 1 exactly when at least one alias was flagged in that run, and `fail` is never 1 while `done` is 0.
- R9: A `start` pulse while `busy` is high is ignored, and the run in progress continues unchanged.
- R10: With a fault-free memory, the run ends with `fail` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a two-pass run (ignored while busy) |
| region_base | input | ADDR_W | Byte address of the region start |
| region_size | input | ADDR_W+1 | Region length in bytes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held until next start) |
| fail | output | 1 | At least one alias found (qualified by done) |
| fault_test_addr | output | ADDR_W | Probe address of the first alias |
| fault_target_addr | output | ADDR_W | Partner address of the first alias |
| fault_mask | output | ADDR_W | Mask of the first alias |

## Verification
Some internal faults show up at the memory port within a single step of the walk. A mask register that skips or repeats a bit changes the write count, or makes an access fall outside the region, on the very step it goes wrong. An inverse register that was captured from the wrong cycle puts wrong write data on the port two cycles after the partner read. Faults in the pass select or in the fault log show up only at `done`: the split of writes between the two probe addresses is wrong, or the recorded address pair and mask do not match the first alias a stuck-address-bit memory must produce.

// File: rtl/aw_pkg.sv
package aw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD1,
    ST_RD1W,
    ST_WR,
    ST_RD2,
    ST_RD2W,
    ST_STEP,
    ST_DONE
  } probe_st_t;
endpackage

// File: rtl/aw_walker.sv
module aw_walker #(
  parameter int ADDR_W     = 12,
  parameter int WORD_BYTES = 4,
  parameter int LAST_OFS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   size,
  output logic [ADDR_W-1:0] test_addr,
  output logic [ADDR_W-1:0] target_addr,
  output logic              target_ok,
  output logic [ADDR_W-1:0] walk_mask,
  output logic              walk_last
);
  localparam logic [ADDR_W-1:0] MASK_INIT = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W:0]   OFS_EXT   = (ADDR_W+1)'(LAST_OFS);

  function automatic logic [ADDR_W:0] region_end(input logic [ADDR_W-1:0] b,
                                                 input logic [ADDR_W:0] s);
    return {1'b0, b} + s;
  endfunction

  function automatic logic [ADDR_W-1:0] last_word(input logic [ADDR_W-1:0] b,
                                                  input logic [ADDR_W:0] s);
    logic [ADDR_W:0] sum;
    sum = region_end(b, s) - OFS_EXT;
    return sum[ADDR_W-1:0];
  endfunction

  function automatic logic inside_region(input logic [ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] b,
                                         input logic [ADDR_W:0] s);
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} < region_end(b, s));
  endfunction

  logic              pass_q;
  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] mask_nxt;

  assign mask_nxt = mask_q << 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      mask_q <= '0;
    end else if (load) begin
      pass_q <= 1'b0;
      mask_q <= MASK_INIT;
    end else if (step) begin
      if (mask_nxt == '0 && !pass_q) begin
        pass_q <= 1'b1;
        mask_q <= MASK_INIT;
      end else begin
        mask_q <= mask_nxt;
      end
    end
  end

  assign test_addr   = pass_q ? last_word(base, size) : base;
  assign target_addr = test_addr ^ mask_q;
  assign target_ok   = (mask_q != '0) && inside_region(target_addr, base, size);
  assign walk_mask   = mask_q;
  assign walk_last   = pass_q && (mask_nxt == '0);
endmodule

// File: rtl/aw_probe.sv
module aw_probe
  import aw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] test_addr,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              target_ok,
  input  logic              walk_last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              load,
  output logic              step,
  output logic              fault_hit,
  output logic              busy,
  output logic              done
);
  probe_st_t         st_q, st_d;
  logic [DATA_W-1:0] inv_q;

  assign load = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign step = (st_q == ST_STEP);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (start) st_d = ST_EVAL;
      ST_EVAL:          st_d = target_ok ? ST_RD1 : ST_STEP;
      ST_RD1:           st_d = ST_RD1W;
      ST_RD1W:          st_d = ST_WR;
      ST_WR:            st_d = ST_RD2;
      ST_RD2:           st_d = ST_RD2W;
      ST_RD2W:          st_d = ST_STEP;
      ST_STEP:          st_d = walk_last ? ST_DONE : ST_EVAL;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      inv_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD1W) inv_q <= ~mem_rdata;
    end
  end

  assign mem_req   = (st_q == ST_RD1) || (st_q == ST_WR) || (st_q == ST_RD2);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? test_addr : target_addr;
  assign mem_wdata = inv_q;
  assign fault_hit = (st_q == ST_RD2W) && (mem_rdata == inv_q);
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/aw_fault_log.sv
module aw_fault_log #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hit,
  input  logic [ADDR_W-1:0] test_addr,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic [ADDR_W-1:0] mask,
  output logic              seen,
  output logic [ADDR_W-1:0] log_test,
  output logic [ADDR_W-1:0] log_target,
  output logic [ADDR_W-1:0] log_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      seen       <= 1'b0;
      log_test   <= '0;
      log_target <= '0;
      log_mask   <= '0;
    end else if (hit && !seen) begin
      seen       <= 1'b1;
      log_test   <= test_addr;
      log_target <= target_addr;
      log_mask   <= mask;
    end
  end
endmodule

// File: rtl/addr_line_walker.sv
module addr_line_walker #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = DATA_W / 8,
  parameter int LAST_OFS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] region_base,
  input  logic [ADDR_W:0]   region_size,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fault_test_addr,
  output logic [ADDR_W-1:0] fault_target_addr,
  output logic [ADDR_W-1:0] fault_mask
);
  logic              load, step, target_ok, walk_last, fault_hit, fault_seen;
  logic [ADDR_W-1:0] test_addr, target_addr, walk_mask;

  aw_walker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LAST_OFS(LAST_OFS)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base(region_base), .size(region_size),
    .test_addr(test_addr), .target_addr(target_addr), .target_ok(target_ok),
    .walk_mask(walk_mask), .walk_last(walk_last)
  );

  aw_probe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_probe (
    .clk(clk), .rst_n(rst_n), .start(start),
    .test_addr(test_addr), .target_addr(target_addr), .target_ok(target_ok),
    .walk_last(walk_last), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .load(load), .step(step), .fault_hit(fault_hit), .busy(busy), .done(done)
  );

  aw_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clear(load), .hit(fault_hit),
    .test_addr(test_addr), .target_addr(target_addr), .mask(walk_mask),
    .seen(fault_seen), .log_test(fault_test_addr),
    .log_target(fault_target_addr), .log_mask(fault_mask)
  );

  assign fail = done && fault_seen;
endmodule

// File: rtl/addr_line_walker_chk.sv
module addr_line_walker_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] region_base,
  input logic [ADDR_W:0]   region_size,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] test_addr,
  input logic [ADDR_W-1:0] walk_mask,
  input logic              fault_hit,
  input logic              fault_seen,
  input logic [ADDR_W-1:0] fault_mask
);
  logic [ADDR_W:0] lim;
  assign lim = {1'b0, region_base} + region_size;

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_mask_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot0(walk_mask));

  p_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ({1'b0, mem_addr} >= {1'b0, region_base}) && ({1'b0, mem_addr} < lim));

  p_inverse_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == ~$past(mem_rdata)));

  p_write_at_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == test_addr));

  p_first_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !fault_seen) |=> (fault_mask == $past(walk_mask)));

  p_fail_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind addr_line_walker addr_line_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .region_base(region_base), .region_size(region_size),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
  .test_addr(test_addr), .walk_mask(walk_mask), .fault_hit(fault_hit),
  .fault_seen(fault_seen), .fault_mask(fault_mask)
);

// File: tb/addr_line_walker_bench.sv
module addr_line_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int WB = 4;
  localparam int WORDS = (1 << AW) / WB;

  typedef struct {
    bit fail;
    int tst, tgt, msk;
    int nbase, nlast;
    int tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] region_base = '0;
  logic [AW:0]   region_size = '0;
  logic mem_req, mem_we, busy, done, fail;
  logic [AW-1:0] mem_addr, fault_test_addr, fault_target_addr, fault_mask;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_line_walker #(.ADDR_W(AW), .DATA_W(DW)) u_addr_line_walker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .region_base(region_base), .region_size(region_size),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail),
    .fault_test_addr(fault_test_addr), .fault_target_addr(fault_target_addr),
    .fault_mask(fault_mask)
  );

  int n_checks = 0, n_fail = 0;
  int cnt_acc = 0, cnt_wr_base = 0, cnt_wr_last = 0, cnt_out = 0, cnt_badinv = 0;
  int probe_lo = 0, probe_hi = 0;
  bit flt_en = 0;
  int flt_bit = 0;
  int scored = 0;
  exp_t exp_q[$];

  logic [DW-1:0] mem_arr [WORDS];
  logic [DW-1:0] last_rd;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic int phys(input int a);
    return flt_en ? (a & ~(1 << flt_bit)) : a;
  endfunction

  // memory model with optional stuck-at-zero address line; watches port rules
  always @(posedge clk) begin
    if (mem_req) begin
      int pa;
      cnt_acc++;
      pa = phys(int'(mem_addr));
      if (int'(mem_addr) < int'(region_base) ||
          int'(mem_addr) >= int'(region_base) + int'(region_size)) cnt_out++;
      if (mem_we) begin
        if (mem_wdata !== ~last_rd) cnt_badinv++;
        if (int'(mem_addr) == probe_lo) cnt_wr_base++;
        else if (int'(mem_addr) == probe_hi) cnt_wr_last++;
        mem_arr[pa / WB] = mem_wdata;
      end else begin
        mem_rdata <= mem_arr[pa / WB];
        last_rd = mem_arr[pa / WB];
      end
    end
  end

  // scoreboard monitor
  bit done_d = 0;
  always @(negedge clk) begin
    if (done && !done_d && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(fail == e.fail, "R8/R10 verdict", int'(fail), int'(e.fail));
      check(cnt_wr_base == e.nbase, "R2/R6 writes at base probe", cnt_wr_base, e.nbase);
      check(cnt_wr_last == e.nlast, "R6/R7 writes at last-word probe", cnt_wr_last, e.nlast);
      check(cnt_acc == 3 * (e.nbase + e.nlast), "R4/R9 access count", cnt_acc,
            3 * (e.nbase + e.nlast));
      check(cnt_out == 0, "R3 accesses outside region", cnt_out, 0);
      check(cnt_badinv == 0, "R4 write data not inverse of read", cnt_badinv, 0);
      if (e.fail) begin
        check(int'(fault_test_addr) == e.tst, "R5 fault probe addr", int'(fault_test_addr), e.tst);
        check(int'(fault_target_addr) == e.tgt, "R5 fault partner addr", int'(fault_target_addr), e.tgt);
        check(int'(fault_mask) == e.msk, "R5 fault mask", int'(fault_mask), e.msk);
      end
      scored++;
    end
    done_d = done;
  end

  // expected-value model built from the requirements
  function automatic exp_t model(input int b, input int s, input int tag);
    exp_t e;
    e = '{fail: 0, tst: 0, tgt: 0, msk: 0, nbase: 0, nlast: 0, tag: tag};
    for (int p = 0; p < 2; p++) begin
      int t;
      t = (p == 0) ? b : ((b + s - 8) & ((1 << AW) - 1));
      for (int m = WB; m < (1 << AW); m = m << 1) begin
        int g;
        g = t ^ m;
        if (g >= b && g < b + s) begin
          if (p == 0) e.nbase++; else e.nlast++;
          if (phys(g) == phys(t) && !e.fail) begin
            e.fail = 1; e.tst = t; e.tgt = g; e.msk = m;
          end
        end
      end
    end
    return e;
  endfunction

  task automatic run_case(input int b, input int s, input bit fen, input int fb,
                          input int restart_after);
    int target;
    @(negedge clk);
    flt_en = fen; flt_bit = fb;
    region_base = AW'(b); region_size = (AW+1)'(s);
    probe_lo = b; probe_hi = (b + s - 8) & ((1 << AW) - 1);
    cnt_acc = 0; cnt_wr_base = 0; cnt_wr_last = 0; cnt_out = 0; cnt_badinv = 0;
    exp_q.push_back(model(b, s, scored));
    target = scored + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_after > 0) begin
      repeat (restart_after) @(negedge clk);
      check(busy == 1'b1, "R9 busy before extra start", int'(busy), 1);
      start = 1'b1;   // must be ignored (R9)
      @(negedge clk);
      start = 1'b0;
    end
    while (scored < target) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem_arr[i] = 32'h5A00_0000 ^ (i * 32'h0001_9E37);
    last_rd = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(fail == 1'b0, "R1 fail after reset", int'(fail), 0);
    check(cnt_acc == 0, "R1 no access before start", cnt_acc, 0);
    // R10 healthy full space
    run_case(0, 4096, 0, 0, 0);
    check(done == 1'b1, "R8 done held", int'(done), 1);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && fail == 1'b0, "R8 done stays, fail low", int'(done), 1);
    // healthy partial region: out-of-range partners skipped (R3)
    run_case(32'h100, 32'h200, 0, 0, 0);
    // small region, four partners (R2)
    run_case(32'h800, 16, 0, 0, 0);
    // stuck line 6, base 0: alias at mask 0x40 (R5, R7)
    run_case(0, 4096, 1, 6, 0);
    // stuck line 9 with offset base, ragged region (R5, R6)
    run_case(32'h300, 32'h400, 1, 9, 0);
    // stuck line 2: lowest tested bit, with ignored restart (R9)
    run_case(32'h40, 32'h800, 1, 2, 12);
    // healthy again after a failing run: fault log cleared (R5, R8)
    run_case(32'h200, 32'h100, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", scored, 7);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule